// File: doc/BRIEF.md
# Multiplexed Three-Digit BCD Scanner

This block drives a three-digit multiplexed display from a signed binary reading. A new reading is offered with a one-cycle `load` strobe together with two overrange flags. The block classifies it (in range positive, in range negative, positive overrange, negative overrange), converts its magnitude to three BCD digits with a sequential shift-and-add-3 converter, and then places the result in a display register.

A free-running scanner visits the most significant, next significant and least significant digit in that order. Each digit is strobed for a programmable number of cycles, and a short blank gap follows every strobe so that the bus changes while no digit is selected. The BCD bus and the three digit strobes are active-low, which suits open-collector style pads.

Negative readings carry a minus code in the top digit. Overrange shows a fixed code in every position. A hold input freezes what is displayed while the scan keeps running.

Top module: `bcd_digit_scanner`

## Requirements
- R1: While `rst_n` is low, and for two rising clock edges after it rises, the block is in reset. In reset it selects the most significant digit (`msd_n` low, the other strobes high), drives `bcd_n` = 4'b1111 (the code 0), and its display register holds the positive value 000.
- R2: The bus is active-low: the 4-bit code of the selected digit appears on `bcd_n` bitwise inverted. A strobe at 0 means that digit is selected.
- R3: At most one of `msd_n`, `nsd_n`, `lsd_n` is low at any time. Digits are selected in the repeating order most, next, least significant.
- R4: Each strobe stays low for `DWELL_CYC` cycles (default 8). It is followed by `GAP_CYC` cycles (default 2) in which all strobes are high and `bcd_n` is 4'b1111. A full scan therefore takes 3*(DWELL_CYC+GAP_CYC) cycles, counted from the first edge after reset.
- R5: A reading from 0 to 999 with no flag set is shown as hundreds, tens and units on the most, next and least significant digit.
- R6: A reading from -1 to -99 with no flag set shows code 4'b1010 (minus) on the most significant digit. The tens and units of its magnitude appear on the next and least significant digits.
- R7: Positive overrange applies when `ovr_pos` is set or the reading exceeds 999. It shows code 4'b1011 on every digit, and it takes priority over negative overrange.
- R8: Negative overrange applies when `ovr_neg` is set or the reading is below -99 (and R7 does not apply). It shows code 4'b1010 on every digit.
- R9: A reading is accepted on a rising edge where `load` is high, `hold` is low and no conversion is in progress. It reaches the display on the rising edge VAL_W+1 cycles later (13 with defaults).
- R10: A `load` on any of the VAL_W edges that follow an accepted reading is ignored. A new reading can be accepted again on the same edge that commits the previous one.
- R11: While `hold` is high, `load` is ignored and the display register does not change. A conversion whose commit edge falls while `hold` is high is discarded. Scanning continues throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Offers `reading` and the flags for acceptance |
| reading | input | VAL_W | Signed binary reading |
| ovr_pos | input | 1 | Positive overrange flag |
| ovr_neg | input | 1 | Negative overrange flag |
| hold | input | 1 | Freezes the displayed reading |
| bcd_n | output | 4 | Active-low BCD code of the selected digit |
| msd_n | output | 1 | Active-low most significant digit strobe |
| nsd_n | output | 1 | Active-low next significant digit strobe |
| lsd_n | output | 1 | Active-low least significant digit strobe |

## Verification
The assertions assume that `load`, `reading`, the flags and `hold` are synchronous to `clk` and stable around each rising edge. They also assume the parameters keep `DWELL_CYC` and `GAP_CYC` at one or more. The bench changes every input only on the falling edge and keeps the default parameters. It offers readings both spaced past the conversion time and inside it, so the ignored-load rule is exercised without the stimulus ever leaving the synchronous assumptions.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    SLOT_MSD = 2'd0,
    SLOT_NSD = 2'd1,
    SLOT_LSD = 2'd2
  } slot_e;

  typedef enum logic [1:0] {
    DISP_POS = 2'd0,
    DISP_NEG = 2'd1,
    DISP_OVP = 2'd2,
    DISP_OVN = 2'd3
  } disp_e;

  localparam int          NUM_DIGITS = 3;
  localparam int          BCD_W      = 4 * NUM_DIGITS;
  localparam int          MAX_POS    = 999;
  localparam int          MIN_NEG    = -99;
  localparam logic [3:0]  CODE_MINUS = 4'hA;
  localparam logic [3:0]  CODE_OVN   = 4'hA;
  localparam logic [3:0]  CODE_OVP   = 4'hB;
  localparam logic [3:0]  BUS_IDLE   = 4'hF;

  function automatic slot_e slot_after(slot_e s);
    case (s)
      SLOT_MSD: slot_after = SLOT_NSD;
      SLOT_NSD: slot_after = SLOT_LSD;
      default:  slot_after = SLOT_MSD;
    endcase
  endfunction

endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int DWELL_CYC = 8,
  parameter int GAP_CYC   = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  output slot_e slot,
  output logic  blank
);

  localparam int LIM   = (DWELL_CYC > GAP_CYC) ? DWELL_CYC : GAP_CYC;
  localparam int CNT_W = $clog2(LIM + 1);
  localparam logic [CNT_W-1:0] DWELL_LAST = CNT_W'(DWELL_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  slot_e            slot_q, slot_d;
  logic             gap_q, gap_d;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    slot_d = slot_q;
    gap_d  = gap_q;
    if (!gap_q && cnt_q == DWELL_LAST) begin
      cnt_d = '0;
      gap_d = 1'b1;
    end else if (gap_q && cnt_q == GAP_LAST) begin
      cnt_d  = '0;
      gap_d  = 1'b0;
      slot_d = slot_after(slot_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= SLOT_MSD;
      gap_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      gap_q  <= gap_d;
    end
  end

  assign slot  = slot_q;
  assign blank = gap_q;

endmodule

// File: rtl/scan_bin2bcd.sv
module scan_bin2bcd
  import scan_pkg::*;
#(
  parameter int MAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MAG_W-1:0] mag,
  output logic             busy,
  output logic             done,
  output logic [BCD_W-1:0] bcd
);

  localparam int SH_W  = BCD_W + MAG_W;
  localparam int CNT_W = $clog2(MAG_W + 1);

  logic [SH_W-1:0]  sh_q, sh_d, adj;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  assign adj[MAG_W-1:0] = sh_q[MAG_W-1:0];

  generate
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_adj
      logic [3:0] nib;
      assign nib = sh_q[MAG_W + 4*g +: 4];
      assign adj[MAG_W + 4*g +: 4] = (nib >= 4'd5) ? nib + 4'd3 : nib;
    end
  endgenerate

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      sh_d   = {{BCD_W{1'b0}}, mag};
      cnt_d  = CNT_W'(MAG_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      sh_d  = adj << 1;
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign bcd  = sh_q[SH_W-1 -: BCD_W];

endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
  import scan_pkg::*;
#(
  parameter int VAL_W     = 12,
  parameter int DWELL_CYC = 8,
  parameter int GAP_CYC   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [VAL_W-1:0] reading,
  input  logic                    ovr_pos,
  input  logic                    ovr_neg,
  input  logic                    hold,
  output logic [3:0]              bcd_n,
  output logic                    msd_n,
  output logic                    nsd_n,
  output logic                    lsd_n
);

  logic rst_meta, rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i_n  <= rst_meta;
    end
  end

  // Classification of the offered reading
  logic signed [VAL_W-1:0] neg_val;
  disp_e                   cls_mode;
  logic [VAL_W-1:0]        cls_mag;

  always_comb begin
    neg_val  = -reading;
    cls_mode = DISP_POS;
    cls_mag  = $unsigned(reading);
    if (ovr_pos || int'(reading) > MAX_POS) begin
      cls_mode = DISP_OVP;
      cls_mag  = '0;
    end else if (ovr_neg || int'(reading) < MIN_NEG) begin
      cls_mode = DISP_OVN;
      cls_mag  = '0;
    end else if (reading < 0) begin
      cls_mode = DISP_NEG;
      cls_mag  = $unsigned(neg_val);
    end
  end

  logic             conv_busy, conv_done, accept, commit;
  logic [BCD_W-1:0] conv_bcd;

  assign accept = load && !hold && !conv_busy;
  assign commit = conv_done && !hold;

  scan_bin2bcd #(.MAG_W(VAL_W)) u_conv (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (accept),
    .mag   (cls_mag),
    .busy  (conv_busy),
    .done  (conv_done),
    .bcd   (conv_bcd)
  );

  // Pending class and display register
  disp_e            pend_mode, pend_mode_d;
  disp_e            disp_mode, disp_mode_d;
  logic [BCD_W-1:0] disp_bcd, disp_bcd_d;

  always_comb begin
    pend_mode_d = accept ? cls_mode : pend_mode;
    disp_mode_d = disp_mode;
    disp_bcd_d  = disp_bcd;
    if (commit) begin
      disp_mode_d = pend_mode;
      disp_bcd_d  = conv_bcd;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pend_mode <= DISP_POS;
      disp_mode <= DISP_POS;
      disp_bcd  <= '0;
    end else begin
      pend_mode <= pend_mode_d;
      disp_mode <= disp_mode_d;
      disp_bcd  <= disp_bcd_d;
    end
  end

  // Scan sequencing and output drive
  slot_e slot;
  logic  blank;

  scan_sequencer #(.DWELL_CYC(DWELL_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk   (clk),
    .rst_n (rst_i_n),
    .slot  (slot),
    .blank (blank)
  );

  logic [3:0] digit_sel, code;

  always_comb begin
    case (slot)
      SLOT_MSD: digit_sel = disp_bcd[11:8];
      SLOT_NSD: digit_sel = disp_bcd[7:4];
      default:  digit_sel = disp_bcd[3:0];
    endcase
    case (disp_mode)
      DISP_OVP: code = CODE_OVP;
      DISP_OVN: code = CODE_OVN;
      DISP_NEG: code = (slot == SLOT_MSD) ? CODE_MINUS : digit_sel;
      default:  code = digit_sel;
    endcase
  end

  logic [NUM_DIGITS-1:0] strobe_n;

  generate
    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_strobe
      assign strobe_n[d] = !(!blank && slot == slot_e'(d));
    end
  endgenerate

  assign msd_n = strobe_n[0];
  assign nsd_n = strobe_n[1];
  assign lsd_n = strobe_n[2];
  assign bcd_n = blank ? BUS_IDLE : ~code;

endmodule

// File: rtl/bcd_digit_scanner_chk.sv
module bcd_digit_scanner_chk
  import scan_pkg::*;
(
  input logic             clk,
  input logic             rst_i_n,
  input logic             hold,
  input logic             msd_n,
  input logic             nsd_n,
  input logic             lsd_n,
  input logic [3:0]       bcd_n,
  input logic [1:0]       slot,
  input logic             blank,
  input logic [1:0]       disp_mode,
  input logic [BCD_W-1:0] disp_bcd,
  input logic [1:0]       pend_mode,
  input logic             conv_busy
);

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(~{msd_n, nsd_n, lsd_n}));

  assert_scan_order_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (slot != $past(slot)) |->
      (($past(slot) == 2'd2) ? (slot == 2'd0) : (slot == $past(slot) + 2'd1)));

  assert_gap_idle_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (msd_n && nsd_n && lsd_n) |-> (bcd_n == 4'hF));

  assert_minus_msd_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (disp_mode == 2'd1 && !msd_n) |-> (bcd_n == ~CODE_MINUS));

  assert_ovp_code_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (disp_mode == 2'd2 && !blank) |-> (bcd_n == ~CODE_OVP));

  assert_ovn_code_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (disp_mode == 2'd3 && !blank) |-> (bcd_n == ~CODE_OVN));

  assert_busy_locks_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    conv_busy |=> $stable(pend_mode));

  assert_hold_freeze_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    hold |=> ($stable(disp_mode) && $stable(disp_bcd)));

endmodule

bind bcd_digit_scanner bcd_digit_scanner_chk u_chk (
  .clk       (clk),
  .rst_i_n   (rst_i_n),
  .hold      (hold),
  .msd_n     (msd_n),
  .nsd_n     (nsd_n),
  .lsd_n     (lsd_n),
  .bcd_n     (bcd_n),
  .slot      (slot),
  .blank     (blank),
  .disp_mode (disp_mode),
  .disp_bcd  (disp_bcd),
  .pend_mode (pend_mode),
  .conv_busy (conv_busy)
);

// File: tb/test_bcd_digit_scanner.sv
module test_bcd_digit_scanner;

  localparam int CLK_PERIOD = 10;
  localparam int VAL_W      = 12;
  localparam int DWELL      = 8;
  localparam int GAP        = 2;
  localparam int SLOT_LEN   = DWELL + GAP;
  localparam int SCAN_LEN   = 3 * SLOT_LEN;
  localparam int LAT        = VAL_W + 1;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    load = 1'b0;
  logic signed [VAL_W-1:0] reading = '0;
  logic                    ovr_pos = 1'b0;
  logic                    ovr_neg = 1'b0;
  logic                    hold = 1'b0;
  logic [3:0]              bcd_n;
  logic                    msd_n, nsd_n, lsd_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_digit_scanner #(.VAL_W(VAL_W), .DWELL_CYC(DWELL), .GAP_CYC(GAP)) i_bcd_digit_scanner (
    .clk(clk), .rst_n(rst_n), .load(load), .reading(reading),
    .ovr_pos(ovr_pos), .ovr_neg(ovr_neg), .hold(hold),
    .bcd_n(bcd_n), .msd_n(msd_n), .nsd_n(nsd_n), .lsd_n(lsd_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (phase %s) actual=%0h expected=%0h at %0t", tag, cur_tag, act, exp, $time);
    end
  endtask

  // Reference model: modes 0 pos, 1 neg, 2 positive overrange, 3 negative overrange
  int sync_cnt = 0, fe = 0, m_mode = 0, m_val = 0;
  int p_mode = 0, p_val = 0, p_at = 0, next_ok = 0;
  bit p_valid = 0;

  function automatic int digit_of(int val, int pos);
    if (pos == 0) return (val / 100) % 10;
    if (pos == 1) return (val / 10) % 10;
    return val % 10;
  endfunction

  function automatic int model_code(int pos);
    case (m_mode)
      2: return 4'hB;
      3: return 4'hA;
      1: return (pos == 0) ? 4'hA : digit_of(m_val, pos);
      default: return digit_of(m_val, pos);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      sync_cnt = 0; fe = 0; m_mode = 0; m_val = 0; p_valid = 0; next_ok = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else begin
      fe++;
      if (p_valid && fe == p_at) begin
        if (!hold) begin m_mode = p_mode; m_val = p_val; end
        p_valid = 0;
      end
      if (load && !hold && fe >= next_ok) begin
        int r;
        r = int'(reading);
        if (ovr_pos || r > 999) begin p_mode = 2; p_val = 0; end
        else if (ovr_neg || r < -99) begin p_mode = 3; p_val = 0; end
        else if (r < 0) begin p_mode = 1; p_val = -r; end
        else begin p_mode = 0; p_val = r; end
        p_valid = 1; p_at = fe + LAT; next_ok = fe + LAT;
      end
    end
    #1;
    begin
      int pos, sl;
      bit gap;
      logic [2:0] exp_str;
      logic [3:0] exp_bus;
      string tag;
      pos = fe % SCAN_LEN;
      sl  = pos / SLOT_LEN;
      gap = (pos % SLOT_LEN) >= DWELL;
      exp_str = gap ? 3'b111 : ~(3'b100 >> sl);
      exp_bus = gap ? 4'hF : ~4'(model_code(sl));
      check({msd_n, nsd_n, lsd_n} == exp_str, "R3", {msd_n, nsd_n, lsd_n}, exp_str);
      case (m_mode)
        1: tag = "R6";
        2: tag = "R7";
        3: tag = "R8";
        default: tag = "R5";
      endcase
      if (gap) tag = "R4";
      check(bcd_n == exp_bus, tag, bcd_n, exp_bus);
    end
  end

  task automatic offer(input int v, input bit op, input bit on);
    @(negedge clk);
    load = 1'b1; reading = VAL_W'(v); ovr_pos = op; ovr_neg = on;
    @(negedge clk);
    load = 1'b0; ovr_pos = 1'b0; ovr_neg = 1'b0;
  endtask

  task automatic show(input int v, input bit op, input bit on);
    offer(v, op, on);
    repeat (LAT + 1) @(negedge clk);
  endtask

  // Independent port-level check: wait for a strobe, compare the inverted code
  task automatic expect_digit(input int pos, input logic [3:0] code, input string tag);
    bit seen = 0;
    for (int k = 0; k < 3 * SCAN_LEN && !seen; k++) begin
      @(negedge clk);
      if ((pos == 0 && !msd_n) || (pos == 1 && !nsd_n) || (pos == 2 && !lsd_n)) seen = 1;
    end
    check(seen && bcd_n == ~code, tag, bcd_n, ~code);
  endtask

  task automatic expect_three(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                              input string tag);
    expect_digit(0, a, tag);
    expect_digit(1, b, tag);
    expect_digit(2, c, tag);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog (phase %s) actual=hung expected=done", cur_tag);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check(!msd_n && nsd_n && lsd_n && bcd_n == 4'hF, "R1", {msd_n, nsd_n, lsd_n, bcd_n}, 7'b0111111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!msd_n && bcd_n == 4'hF, "R1", {msd_n, bcd_n}, 5'b01111);
    expect_three(4'd0, 4'd0, 4'd0, "R1");

    cur_tag = "R5";
    show(407, 0, 0);  expect_three(4'd4, 4'd0, 4'd7, "R5");
    show(999, 0, 0);  expect_three(4'd9, 4'd9, 4'd9, "R5");
    show(0, 0, 0);    expect_three(4'd0, 4'd0, 4'd0, "R2");
    show(86, 0, 0);   expect_three(4'd0, 4'd8, 4'd6, "R5");

    cur_tag = "R6";
    show(-58, 0, 0);  expect_three(4'hA, 4'd5, 4'd8, "R6");
    show(-5, 0, 0);   expect_three(4'hA, 4'd0, 4'd5, "R6");
    show(-99, 0, 0);  expect_three(4'hA, 4'd9, 4'd9, "R6");

    cur_tag = "R7";
    show(1000, 0, 0); expect_three(4'hB, 4'hB, 4'hB, "R7");
    show(5, 1, 0);    expect_three(4'hB, 4'hB, 4'hB, "R7");
    show(-300, 1, 1); expect_three(4'hB, 4'hB, 4'hB, "R7");

    cur_tag = "R8";
    show(-100, 0, 0); expect_three(4'hA, 4'hA, 4'hA, "R8");
    show(300, 0, 1);  expect_three(4'hA, 4'hA, 4'hA, "R8");

    cur_tag = "R9";
    show(123, 0, 0);
    offer(654, 0, 0);
    repeat (LAT - 2) @(negedge clk);
    expect_digit(2, 4'd3, "R9");
    repeat (2 * SCAN_LEN) @(negedge clk);
    expect_three(4'd6, 4'd5, 4'd4, "R9");

    cur_tag = "R10";
    offer(111, 0, 0);
    repeat (4) @(negedge clk);
    offer(222, 0, 0);
    repeat (LAT + 1) @(negedge clk);
    expect_three(4'd1, 4'd1, 4'd1, "R10");
    @(negedge clk);
    load = 1'b1; reading = VAL_W'(555);
    repeat (LAT) @(negedge clk);
    reading = VAL_W'(777);
    @(negedge clk);
    load = 1'b0;
    repeat (LAT + 1) @(negedge clk);
    expect_three(4'd7, 4'd7, 4'd7, "R10");

    cur_tag = "R11";
    show(345, 0, 0);
    @(negedge clk); hold = 1'b1;
    offer(678, 0, 0);
    repeat (LAT + 2) @(negedge clk);
    expect_three(4'd3, 4'd4, 4'd5, "R11");
    @(negedge clk); hold = 1'b0;
    offer(246, 0, 0);
    repeat (4) @(negedge clk);
    hold = 1'b1;
    repeat (LAT) @(negedge clk);
    expect_three(4'd3, 4'd4, 4'd5, "R11");
    hold = 1'b0;
    repeat (SCAN_LEN) @(negedge clk);
    expect_three(4'd3, 4'd4, 4'd5, "R11");
    show(246, 0, 0);  expect_three(4'd2, 4'd4, 4'd6, "R11");

    cur_tag = "R4";
    repeat (2 * SCAN_LEN) @(negedge clk);
    finish_run();
  end

endmodule